// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block is the register front end of a two-drive floppy controller. Software sees two 16-bit registers on a simple register bus: a control/status word and a shared data word. A write that sets the start bit while the sequencer is idle selects one of eight functions. The block then collects that function's parameter words one at a time through the data word. A transfer-request flag paces the exchange: software writes the next parameter only while the flag is up.

Once the last parameter is in, the block sends a one-cycle start pulse, together with the collected arguments, to a back end that does the media work. The back end later returns a completion strobe with an error code and an error-status word. Two functions are finished inside the block. Read-status completes after a fixed command delay. Set-density completes at once, with an error, when its confirmation key is wrong. On completion the block sets done, raises a level interrupt if enabled, flags an error when one is present, and places the error status in the data word.

Top module: `fcs_top`

## Requirements
- R1: After reset the control word reads 0x0800, the data word reads 0 and `irq` is low. Bit 11 always reads 1, and the start bit (bit 0) and the clear bit (bit 14) always read 0. Field positions: bits 3:1 function, bit 4 drive, bit 5 done, bit 6 interrupt enable, bit 7 transfer request, bit 8 density, bits 13:12 address extension, bit 15 error.
- R2: A control write with bit 14 set clears every register and returns the sequencer to idle. It takes priority over a start bit in the same write.
- R3: A start write is accepted only while idle. Acceptance clears error, done and the interrupt, latches the enable, function, drive, density and extension fields, and sets transfer request at once if the function takes parameters. Function codes: 0 fill, 1 empty, 2 write, 3 read, 4 set-density, 5 read-status, 6 write-deleted, 7 extended-status.
- R4: Fill and empty take a word count (masked to 8 bits) and then a bus address (16 bits). Read, write and write-deleted take a sector (masked to 7 bits) and then a track (masked to 8 bits). Set-density takes one confirmation byte. Extended-status takes one 16-bit address.
- R5: While busy, a data write is ignored unless transfer request is set. A data write to the odd byte address (`bus_addr[0]`=1) is always ignored. While idle, a data write simply loads the data word.
- R6: Each accepted parameter clears transfer request. When another parameter is still due, the flag rises again exactly XFER_GAP cycles later.
- R7: After the last parameter, `cmd_start` pulses for one cycle with the arguments. A `rsp_done` strobe completes the command: done is set, the sequencer goes idle and the data word is loaded with `rsp_status`.
- R8: At completion the error bit is set when the error code is nonzero or when any status bit in positions 0, 3, 4, 10 or 11 is set. The error code appears on `err_code`.
- R9: A set-density confirmation byte other than 0x49 completes the command with error code 0xA8 and no start pulse. A byte of 0x49 starts the back end.
- R10: Read-status issues no start pulse and sets done exactly CMD_DELAY cycles after acceptance.
- R11: `irq` rises at completion when enable is set and stays high until cleared. A non-start control write that clears enable drops it. A write that sets enable while done is set and enable was clear raises it.
- R12: A byte write to the control word at the odd address places data bits 7:0 into the high byte, and at the even address into the low byte, keeping the other byte. While busy, a rejected control write changes only the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Bit 1 selects the data word, bit 0 the odd byte |
| bus_byte | input | 1 | Byte-wide write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word |
| irq | output | 1 | Interrupt request level |
| cmd_start | output | 1 | One-cycle start to the back end |
| cmd_func | output | 3 | Latched function |
| cmd_drive | output | 1 | Latched drive select |
| cmd_density | output | 1 | Latched density |
| cmd_aext | output | 2 | Latched address extension |
| cmd_arg0 | output | 16 | First parameter, masked |
| cmd_arg1 | output | 16 | Second parameter, masked |
| rsp_done | input | 1 | Back-end completion strobe |
| rsp_code | input | 8 | Back-end error code |
| rsp_status | input | 12 | Back-end error status |
| err_code | output | 8 | Error code of the last completion |

## Verification
Several rules are checked by the assertions on every cycle. Transfer request is never up while idle and never together with done. A start pulse lasts one cycle, follows an accepted parameter write and never belongs to read-status. The interrupt never rises while enable is clear. Only the bench's scenarios can show the rest: the parameter order and masks for each function, the exact gap and command-delay cycle counts, the rejected set-density key, byte-lane merging, the ignored writes and the error-bit rule.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   localparam int WORD_W = 16;

   localparam int B_GO    = 0;
   localparam int B_DRV   = 4;
   localparam int B_DONE  = 5;
   localparam int B_IE    = 6;
   localparam int B_TR    = 7;
   localparam int B_DEN   = 8;
   localparam int B_FIXED = 11;
   localparam int B_CLR   = 14;
   localparam int B_ERR   = 15;

   typedef enum logic [2:0] {
      FN_FILL    = 3'd0,
      FN_EMPTY   = 3'd1,
      FN_WRITE   = 3'd2,
      FN_READ    = 3'd3,
      FN_SETDEN  = 3'd4,
      FN_RDSTAT  = 3'd5,
      FN_WRDEL   = 3'd6,
      FN_EXTSTAT = 3'd7
   } fcs_func_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARG0,
      ST_GAP,
      ST_ARG1,
      ST_CMD,
      ST_BUSY
   } fcs_state_e;

   typedef struct packed {
      logic [1:0]        nargs;
      logic              confirm;
      logic [WORD_W-1:0] mask0;
      logic [WORD_W-1:0] mask1;
   } fcs_plan_t;

endpackage

// File: rtl/fcs_func_decode.sv
module fcs_func_decode
   import fcs_pkg::*;
(
   input  logic [2:0] func,
   output fcs_plan_t  plan
);

   always_comb begin
      plan = '0;
      case (func)
         FN_FILL, FN_EMPTY: begin
            plan.nargs = 2'd2;
            plan.mask0 = 16'h00FF;
            plan.mask1 = 16'hFFFF;
         end
         FN_WRITE, FN_READ, FN_WRDEL: begin
            plan.nargs = 2'd2;
            plan.mask0 = 16'h007F;
            plan.mask1 = 16'h00FF;
         end
         FN_SETDEN: begin
            plan.nargs   = 2'd1;
            plan.confirm = 1'b1;
            plan.mask0   = 16'h00FF;
         end
         FN_EXTSTAT: begin
            plan.nargs = 2'd1;
            plan.mask0 = 16'hFFFF;
         end
         default: plan = '0;
      endcase
   end

endmodule

// File: rtl/fcs_timer.sv
module fcs_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   input  logic          run,
   output logic          expired
);

   logic [TW-1:0] cnt;

   generate
      if (TW < 1) begin : g_bad_width
         $error("fcs_timer: TW must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt <= '0;
      else if (load)               cnt <= load_val;
      else if (run && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired = run && (cnt == '0);

endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
   import fcs_pkg::*;
#(
   parameter int          XFER_GAP         = 4,
   parameter int          CMD_DELAY        = 12,
   parameter int          ECODE_W          = 8,
   parameter logic [7:0]  CONFIRM_KEY      = 8'h49,
   parameter logic [ECODE_W-1:0] BAD_CONFIRM_CODE = 8'hA8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               go_ok,
   input  fcs_plan_t          go_plan,
   input  logic               is_rdstat,
   input  logic               arg_wr,
   input  logic [WORD_W-1:0]  arg_data,
   input  logic               rsp_done,
   input  logic [ECODE_W-1:0] rsp_code,
   output logic               busy,
   output logic               tr,
   output logic [WORD_W-1:0]  arg0,
   output logic [WORD_W-1:0]  arg1,
   output logic               start,
   output logic               fin,
   output logic [ECODE_W-1:0] fin_code,
   output logic               fin_rsp
);

   localparam int MAXD = (XFER_GAP > CMD_DELAY) ? XFER_GAP : CMD_DELAY;
   localparam int TW   = $clog2(MAXD + 1);

   generate
      if (XFER_GAP < 1) begin : g_bad_gap
         $error("fcs_seq: XFER_GAP must be at least 1");
      end
      if (CMD_DELAY < 1) begin : g_bad_delay
         $error("fcs_seq: CMD_DELAY must be at least 1");
      end
   endgenerate

   fcs_state_e state;
   fcs_plan_t  plan_q;
   logic          t_load, t_run, t_exp;
   logic [TW-1:0] t_val;
   logic          bad_key;

   assign busy    = (state != ST_IDLE);
   assign bad_key = plan_q.confirm && (arg_data[7:0] != CONFIRM_KEY);

   always_comb begin
      t_load = 1'b0;
      t_val  = TW'(XFER_GAP - 1);
      if (state == ST_IDLE && go_ok && go_plan.nargs == 2'd0) begin
         t_load = 1'b1;
         t_val  = TW'(CMD_DELAY - 1);
      end else if (state == ST_ARG0 && arg_wr && plan_q.nargs == 2'd2) begin
         t_load = 1'b1;
      end
   end

   assign t_run = (state == ST_GAP) || (state == ST_CMD);

   fcs_timer #(.TW(TW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .run      (t_run),
      .expired  (t_exp)
   );

   always_comb begin
      fin      = 1'b0;
      fin_code = '0;
      fin_rsp  = 1'b0;
      case (state)
         ST_ARG0: if (arg_wr && plan_q.nargs == 2'd1 && bad_key) begin
            fin      = 1'b1;
            fin_code = BAD_CONFIRM_CODE;
         end
         ST_CMD:  if (t_exp) fin = 1'b1;
         ST_BUSY: if (rsp_done) begin
            fin      = 1'b1;
            fin_code = rsp_code;
            fin_rsp  = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         state  <= ST_IDLE;
         plan_q <= '0;
         tr     <= 1'b0;
         arg0   <= '0;
         arg1   <= '0;
         start  <= 1'b0;
      end else begin
         start <= 1'b0;
         case (state)
            ST_IDLE: if (go_ok) begin
               plan_q <= go_plan;
               arg0   <= '0;
               arg1   <= '0;
               if (go_plan.nargs != 2'd0) begin
                  state <= ST_ARG0;
                  tr    <= 1'b1;
               end else begin
                  state <= ST_CMD;
               end
            end
            ST_ARG0: if (arg_wr) begin
               tr   <= 1'b0;
               arg0 <= arg_data & plan_q.mask0;
               if (plan_q.nargs == 2'd2)  state <= ST_GAP;
               else if (bad_key)          state <= ST_IDLE;
               else begin
                  state <= ST_BUSY;
                  start <= 1'b1;
               end
            end
            ST_GAP: if (t_exp) begin
               tr    <= 1'b1;
               state <= ST_ARG1;
            end
            ST_ARG1: if (arg_wr) begin
               tr    <= 1'b0;
               arg1  <= arg_data & plan_q.mask1;
               state <= ST_BUSY;
               start <= 1'b1;
            end
            ST_CMD:  if (t_exp)    state <= ST_IDLE;
            ST_BUSY: if (rsp_done) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R5: transfer request only while a command is in progress
   a_r5_tr_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tr |-> (state != ST_IDLE));

   // R7: start is a single-cycle pulse
   a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);

   // R7: start follows an accepted parameter write
   a_r7_start_after_arg: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start) |-> $past(arg_wr));

   // R10: read-status never reaches the back end
   a_r10_rdstat_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && go_ok && is_rdstat) |=> (state == ST_CMD && !start));

endmodule

// File: rtl/fcs_top.sv
module fcs_top
   import fcs_pkg::*;
#(
   parameter int          XFER_GAP         = 4,
   parameter int          CMD_DELAY        = 12,
   parameter int          ESR_W            = 12,
   parameter int          ECODE_W          = 8,
   parameter logic [7:0]  CONFIRM_KEY      = 8'h49,
   parameter logic [7:0]  BAD_CONFIRM_CODE = 8'hA8,
   parameter logic [11:0] ESR_ERR_MASK     = 12'hC19
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bus_wr,
   input  logic [1:0]   bus_addr,
   input  logic         bus_byte,
   input  logic [15:0]  bus_wdata,
   output logic [15:0]  bus_rdata,
   output logic         irq,
   output logic         cmd_start,
   output logic [2:0]   cmd_func,
   output logic         cmd_drive,
   output logic         cmd_density,
   output logic [1:0]   cmd_aext,
   output logic [15:0]  cmd_arg0,
   output logic [15:0]  cmd_arg1,
   input  logic         rsp_done,
   input  logic [7:0]   rsp_code,
   input  logic [11:0]  rsp_status,
   output logic [7:0]   err_code
);

   localparam int PAD_W = WORD_W - ESR_W;

   generate
      if (ESR_W != 12 || ECODE_W != 8) begin : g_bad_widths
         $error("fcs_top: status must be 12 bits and error code 8 bits");
      end
   endgenerate

   logic              ie, drv, den, done, err, irq_q;
   logic [2:0]        func_q;
   logic [1:0]        aext;
   logic [WORD_W-1:0] dbr;
   logic [ESR_W-1:0]  esr;
   logic [ECODE_W-1:0] ecode;

   logic [WORD_W-1:0] csr_rd, wdat;
   logic              wr_csr, wr_dat, clear_wr, go_ok, arg_wr, dbr_wr;
   logic              ie_nxt, irq_pre, irq_nxt;
   logic              busy, tr, fin, fin_rsp;
   logic [ECODE_W-1:0] fin_code;
   logic [ESR_W-1:0]  esr_new;
   logic              err_set;
   fcs_plan_t         go_plan;

   assign csr_rd = {err, 1'b0, aext, 1'b1, 2'b00, den, tr, ie, done, drv, func_q, 1'b0};

   // byte-lane merge for control writes
   always_comb begin
      if (!bus_byte)        wdat = bus_wdata;
      else if (bus_addr[0]) wdat = {bus_wdata[7:0], csr_rd[7:0]};
      else                  wdat = {csr_rd[15:8], bus_wdata[7:0]};
   end

   logic unused_wdat;
   assign unused_wdat = ^{wdat[11:9], wdat[7], wdat[5]};

   assign wr_csr   = bus_wr && !bus_addr[1];
   assign wr_dat   = bus_wr &&  bus_addr[1] && !bus_addr[0];
   assign clear_wr = wr_csr && wdat[B_CLR];
   assign go_ok    = wr_csr && !clear_wr && wdat[B_GO] && !busy;
   assign arg_wr   = wr_dat && busy && tr;
   assign dbr_wr   = wr_dat && (!busy || tr);

   fcs_func_decode i_decode (
      .func (wdat[3:1]),
      .plan (go_plan)
   );

   fcs_seq #(
      .XFER_GAP         (XFER_GAP),
      .CMD_DELAY        (CMD_DELAY),
      .ECODE_W          (ECODE_W),
      .CONFIRM_KEY      (CONFIRM_KEY),
      .BAD_CONFIRM_CODE (BAD_CONFIRM_CODE)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear_wr),
      .go_ok     (go_ok),
      .go_plan   (go_plan),
      .is_rdstat (wdat[3:1] == FN_RDSTAT),
      .arg_wr    (arg_wr),
      .arg_data  (bus_wdata),
      .rsp_done  (rsp_done),
      .rsp_code  (rsp_code),
      .busy      (busy),
      .tr        (tr),
      .arg0      (cmd_arg0),
      .arg1      (cmd_arg1),
      .start     (cmd_start),
      .fin       (fin),
      .fin_code  (fin_code),
      .fin_rsp   (fin_rsp)
   );

   // interrupt enable and request next values
   always_comb begin
      ie_nxt  = wr_csr ? wdat[B_IE] : ie;
      irq_pre = irq_q;
      if (go_ok)                                irq_pre = 1'b0;
      else if (wr_csr && !wdat[B_IE])           irq_pre = 1'b0;
      else if (wr_csr && done && !ie)           irq_pre = 1'b1;
      irq_nxt = irq_pre | (fin & ie_nxt);
   end

   assign esr_new = fin_rsp ? rsp_status : esr;
   assign err_set = (fin_code != '0) || ((esr_new & ESR_ERR_MASK) != '0);

   always_ff @(posedge clk) begin
      if (!rst_n || clear_wr) begin
         ie     <= 1'b0;
         irq_q  <= 1'b0;
         func_q <= '0;
         drv    <= 1'b0;
         den    <= 1'b0;
         aext   <= '0;
         done   <= 1'b0;
         err    <= 1'b0;
         dbr    <= '0;
         esr    <= '0;
         ecode  <= '0;
      end else begin
         ie    <= ie_nxt;
         irq_q <= irq_nxt;
         if (go_ok || (wr_csr && !busy)) begin
            func_q <= wdat[3:1];
            drv    <= wdat[B_DRV];
            den    <= wdat[B_DEN];
            aext   <= wdat[13:12];
         end
         if (go_ok) begin
            done <= 1'b0;
            err  <= 1'b0;
         end
         if (dbr_wr) dbr <= bus_wdata;
         if (fin) begin
            done  <= 1'b1;
            err   <= err_set;
            esr   <= esr_new;
            ecode <= fin_code;
            dbr   <= {{PAD_W{1'b0}}, esr_new};
         end
      end
   end

   assign bus_rdata   = bus_addr[1] ? dbr : csr_rd;
   assign irq         = irq_q;
   assign cmd_func    = func_q;
   assign cmd_drive   = drv;
   assign cmd_density = den;
   assign cmd_aext    = aext;
   assign err_code    = ecode;

   // R11: the request never rises while enable is clear
   a_r11_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> ie);

   // R3: done and transfer request are never up together
   a_r3_done_tr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && tr));

   // R12: a rejected control write while busy keeps the function
   a_r12_busy_keeps_func: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_csr && !clear_wr) |=> (func_q == $past(func_q)));

   // R2: a clear write leaves the block idle with done low
   a_r2_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      clear_wr |=> (!done && !tr && !irq_q));

endmodule

// File: tb/test_fcs_top.sv
module test_fcs_top;

   localparam int GAP = 4;
   localparam int DLY = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'b00;
   logic        bus_byte = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq, cmd_start, cmd_drive, cmd_density;
   logic [2:0]  cmd_func;
   logic [1:0]  cmd_aext;
   logic [15:0] cmd_arg0, cmd_arg1;
   logic        rsp_done = 1'b0;
   logic [7:0]  rsp_code = '0;
   logic [11:0] rsp_status = '0;
   logic [7:0]  err_code;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   typedef struct {
      logic [2:0]  f;
      logic [15:0] a0;
      logic [15:0] a1;
   } exp_t;
   exp_t expq[$];

   always #4 clk = ~clk;

   fcs_top #(.XFER_GAP(GAP), .CMD_DELAY(DLY)) i_fcs_top (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_byte(bus_byte), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .cmd_start(cmd_start), .cmd_func(cmd_func),
      .cmd_drive(cmd_drive), .cmd_density(cmd_density), .cmd_aext(cmd_aext),
      .cmd_arg0(cmd_arg0), .cmd_arg1(cmd_arg1), .rsp_done(rsp_done),
      .rsp_code(rsp_code), .rsp_status(rsp_status), .err_code(err_code)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pop an expected start for every pulse seen
   always @(negedge clk) begin
      if (rst_n && cmd_start) begin
         checks++;
         if (expq.size() == 0) begin
            failures++;
            $display("FAIL R7 actual=unexpected start f=%0d expected=none", cmd_func);
         end else begin
            exp_t e;
            e = expq.pop_front();
            if (cmd_func !== e.f || cmd_arg0 !== e.a0 || cmd_arg1 !== e.a1) begin
               failures++;
               $display("FAIL R4 actual=%0d/%h/%h expected=%0d/%h/%h",
                        cmd_func, cmd_arg0, cmd_arg1, e.f, e.a0, e.a1);
            end
         end
      end
   end

   task automatic push(input logic [2:0] f, input logic [15:0] a0, input logic [15:0] a1);
      exp_t e;
      e.f = f; e.a0 = a0; e.a1 = a1;
      expq.push_back(e);
   endtask

   task automatic wr(input logic [1:0] a, input logic byt, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_byte = byt; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_byte = 1'b0;
   endtask

   task automatic csr_wr(input logic [15:0] d);  wr(2'b00, 1'b0, d); endtask
   task automatic dat_wr(input logic [15:0] d);  wr(2'b10, 1'b0, d); endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic rsp(input logic [7:0] c, input logic [11:0] s);
      @(negedge clk);
      rsp_done = 1'b1; rsp_code = c; rsp_status = s;
      @(negedge clk);
      rsp_done = 1'b0;
   endtask

   // count cycles until a control bit goes high
   task automatic count_until(input int bitpos, output int n);
      logic [15:0] v;
      n = 0;
      rd(2'b00, v);
      while (!v[bitpos] && n < 1000) begin
         @(negedge clk);
         n++;
         rd(2'b00, v);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'b00, v); chk("R1 csr", v, 16'h0800);
      rd(2'b10, v); chk("R1 dbr", v, 16'h0000);
      chk("R1 irq", {15'b0, irq}, 16'h0000);

      // R5 idle data write and odd-address write
      dat_wr(16'h1234);
      rd(2'b10, v); chk("R5 idle dbr", v, 16'h1234);
      wr(2'b11, 1'b0, 16'hFFFF);
      rd(2'b10, v); chk("R5 odd ignored", v, 16'h1234);

      // R3/R4/R6/R7 fill with drive 1 and enable
      csr_wr(16'h0051);
      rd(2'b00, v); chk("R3 fill accept", v, 16'h08D0);
      dat_wr(16'h0312);
      rd(2'b00, v); chk("R6 tr cleared", {15'b0, v[7]}, 16'h0000);
      count_until(7, n); chk("R6 gap", 16'(n), 16'(GAP));
      push(3'd0, 16'h0012, 16'hABCD);
      dat_wr(16'hABCD);
      rsp(8'h00, 12'h080);
      rd(2'b00, v); chk("R7 fill done", v, 16'h0870);
      rd(2'b10, v); chk("R7 status in dbr", v, 16'h0080);
      chk("R11 irq at done", {15'b0, irq}, 16'h0001);

      // R11 enable handling
      csr_wr(16'h0000);
      chk("R11 clear ie drops", {15'b0, irq}, 16'h0000);
      csr_wr(16'h0040);
      chk("R11 set ie raises", {15'b0, irq}, 16'h0001);
      rd(2'b00, v); chk("R11 csr", v, 16'h0860);

      // R4/R5/R8 read with masks, ignored write in gap, status error
      csr_wr(16'h0007);
      chk("R3 go clears irq", {15'b0, irq}, 16'h0000);
      dat_wr(16'h00FF);
      dat_wr(16'h5555);
      rd(2'b10, v); chk("R5 busy no tr ignored", v, 16'h00FF);
      count_until(7, n);
      push(3'd3, 16'h007F, 16'h00FF);
      dat_wr(16'h01FF);
      rsp(8'h00, 12'h010);
      rd(2'b00, v); chk("R8 status error", v, 16'h8826);
      chk("R11 no irq ie off", {15'b0, irq}, 16'h0000);

      // R8 write-deleted with nonzero code
      csr_wr(16'h000D);
      dat_wr(16'h0005);
      count_until(7, n);
      push(3'd6, 16'h0005, 16'h0010);
      dat_wr(16'h0010);
      rsp(8'h40, 12'h000);
      rd(2'b00, v); chk("R8 code error", v, 16'h882C);
      chk("R8 err_code", {8'h0, err_code}, 16'h0040);

      // R12/R3 busy writes, then R2 clear with start
      csr_wr(16'h0005);
      csr_wr(16'h000F);
      csr_wr(16'h0047);
      rd(2'b00, v); chk("R12 busy only ie", v, 16'h08C4);
      csr_wr(16'h4001);
      rd(2'b00, v); chk("R2 csr cleared", v, 16'h0800);
      rd(2'b10, v); chk("R2 dbr cleared", v, 16'h0000);
      dat_wr(16'h0AAA);
      rd(2'b10, v); chk("R2 idle after clear", v, 16'h0AAA);

      // R9 set-density bad and good key
      csr_wr(16'h0009);
      dat_wr(16'h0012);
      rd(2'b00, v); chk("R9 bad key", v, 16'h8828);
      chk("R9 code", {8'h0, err_code}, 16'h00A8);
      csr_wr(16'h0009);
      push(3'd4, 16'h0049, 16'h0000);
      dat_wr(16'h1249);
      rsp(8'h00, 12'h000);
      rd(2'b00, v); chk("R9 good key", v, 16'h0828);

      // R10 read-status delay
      csr_wr(16'h000B);
      rd(2'b00, v); chk("R10 no tr", {14'b0, v[7], v[5]}, 16'h0000);
      count_until(5, n); chk("R10 delay", 16'(n), 16'(DLY));
      rd(2'b00, v); chk("R10 done", v, 16'h082A);

      // R4 extended status
      csr_wr(16'h000F);
      push(3'd7, 16'h2468, 16'h0000);
      dat_wr(16'h2468);
      rsp(8'h00, 12'h000);
      rd(2'b00, v); chk("R4 extstat done", v, 16'h082E);

      // R12 byte lanes
      wr(2'b01, 1'b1, 16'h0030);
      rd(2'b00, v); chk("R12 odd byte", v, 16'h382E);
      chk("R12 aext", {14'b0, cmd_aext}, 16'h0003);
      wr(2'b00, 1'b1, 16'h0040);
      rd(2'b00, v); chk("R12 even byte", v, 16'h3860);
      chk("R11 byte ie raises", {15'b0, irq}, 16'h0001);

      repeat (4) @(negedge clk);
      checks++;
      if (expq.size() != 0) begin
         failures++;
         $display("FAIL R7 actual=%0d pending expected=0", expq.size());
      end
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule